// File: doc/BRIEF.md
# Condition Field Mask-Map Unit

This block keeps a small file of eight 4-bit condition fields and applies per-field editing operations to it. Within each field the bit order from most to least significant is LT, GT, EQ, SO. The field-map operation takes one source field, keeps the bits that a 4-bit keep mask selects, and can merge in the destination's own unselected bits. It then flips bits through a 4-bit XOR map and writes the result to a destination field. With this sequence every bit of the destination can be copied, held, inverted, forced to one or forced to zero. A bit never changes position.

The bit-set operation reduces a masked and mapped source field to one bit: the OR of its four bits. It writes that bit into a single bit of the file, chosen by a 5-bit bit address, and every other bit stays as it was.

A request is presented for one cycle with `req_valid` high and commits on the next rising clock edge. A combinational read port shows the field chosen by `rd_idx`. In the cycle of a request it still shows the value from before that request.

Top module: `cfmm_unit`

## Requirements
- R1: While `rst` is high at a rising edge, all eight fields become 4'b0000 at that edge.
- R2: A field-map request (`req_op`=0) with `merge_en`=0 sets field `dst_idx` to (field[`src_idx`] & `keep_mask`) ^ `flip_map` at the next rising edge.
- R3: A field-map request with `merge_en`=1 sets field `dst_idx` to ((field[`src_idx`] & `keep_mask`) | (old field[`dst_idx`] & ~`keep_mask`)) ^ `flip_map` at the next rising edge.
- R4: Each bit of a field-map result depends only on the same bit position of the source, the old destination, the mask and the map. Bit 3 is LT, bit 2 GT, bit 1 EQ, bit 0 SO.
- R5: A bit-set request (`req_op`=1) addresses field `bit_addr[2:0]`, and within it the bit at position 3 - `bit_addr[4:3]`. The value 0 in `bit_addr[4:3]` selects LT and the value 3 selects SO.
- R6: A bit-set request writes the OR of the four bits of (field[`src_idx`] & `keep_mask`) ^ `flip_map` into the addressed bit. The other three bits of that field and all other fields keep their values.
- R7: With `req_valid` low, no field changes whatever the other inputs are. A field-map request changes no field other than `dst_idx`.
- R8: `rd_field` equals field[`rd_idx`] combinationally. In the cycle a request is presented it shows the value from before that request, and the new value appears after the next rising edge.
- R9: When `src_idx` equals `dst_idx`, a field-map request uses the field's value from before the request for both the source and the merge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 1 | 0 = field-map, 1 = bit-set |
| src_idx | input | 3 | Source field index |
| dst_idx | input | 3 | Destination field index (field-map) |
| merge_en | input | 1 | Merge unselected destination bits (field-map) |
| keep_mask | input | 4 | Bits of the source that are kept |
| flip_map | input | 4 | XOR map applied after masking and merging |
| bit_addr | input | 5 | Target bit for bit-set: [2:0] field, [4:3] bit (0 = LT) |
| rd_idx | input | 3 | Read port field index |
| rd_field | output | 4 | Current value of field `rd_idx` |

## Verification
The field file is the only state, so the read port exposes any corruption directly. After each request the bench reads all eight fields in the same cycle, before the next edge. A wrong index decode, a lost merge, a swapped bit position or a stray write to a neighbouring field therefore shows as a mismatch one cycle after the faulty request. Exhaustive sweeps cover every mask, map and merge combination and every bit address. Each request also compares the read port before the edge, which exposes a write that lands a cycle early.

// File: rtl/cfmm_pkg.sv
package cfmm_pkg;

    parameter int unsigned CF_COUNT  = 8;
    parameter int unsigned CF_W      = 4;
    localparam int unsigned CF_IDX_W = $clog2(CF_COUNT);
    localparam int unsigned BIT_SEL_W = $clog2(CF_W);
    localparam int unsigned BADDR_W  = CF_IDX_W + BIT_SEL_W;

    typedef logic [CF_W-1:0]      cfield_t;
    typedef logic [CF_IDX_W-1:0]  cidx_t;
    typedef logic [BIT_SEL_W-1:0] bsel_t;
    typedef logic [BADDR_W-1:0]   baddr_t;
    typedef logic [CF_COUNT-1:0][CF_W-1:0] cfile_t;

    typedef enum logic {
        OP_FIELD_MAP = 1'b0,
        OP_BIT_SET   = 1'b1
    } cf_op_e;

    typedef struct packed {
        logic    en;
        cidx_t   idx;
        cfield_t data;
    } cf_wr_t;

    // keep, optionally merge, then flip
    function automatic cfield_t mask_map(cfield_t src, cfield_t old, cfield_t keep,
                                         cfield_t flip, logic merge);
        cfield_t r;
        r = src & keep;
        if (merge) r = r | (old & ~keep);
        return r ^ flip;
    endfunction

    function automatic logic reduce_bit(cfield_t src, cfield_t keep, cfield_t flip);
        return |((src & keep) ^ flip);
    endfunction

    function automatic cidx_t addr_field(baddr_t a);
        return a[CF_IDX_W-1:0];
    endfunction

    // select 0 names the most significant bit (LT)
    function automatic bsel_t addr_pos(baddr_t a);
        return bsel_t'(CF_W-1) - a[BADDR_W-1:CF_IDX_W];
    endfunction

endpackage

// File: rtl/cfmm_field_file.sv
module cfmm_field_file
    import cfmm_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  cf_wr_t wr,
    output cfile_t fields
);

    cfile_t fields_q;

    for (genvar g = 0; g < CF_COUNT; g++) begin : g_field
        always_ff @(posedge clk) begin
            if (rst) begin
                fields_q[g] <= '0;
            end else if (wr.en && (wr.idx == cidx_t'(g))) begin
                fields_q[g] <= wr.data;
            end
        end
    end

    assign fields = fields_q;

endmodule

// File: rtl/cfmm_op_unit.sv
module cfmm_op_unit
    import cfmm_pkg::*;
(
    input  logic    valid,
    input  cf_op_e  op,
    input  cidx_t   dst_idx,
    input  cfield_t src_field,
    input  cfield_t dst_field,
    input  cfield_t tgt_field,
    input  baddr_t  bit_addr,
    input  logic    merge,
    input  cfield_t keep,
    input  cfield_t flip,
    output cf_wr_t  wr
);

    bsel_t   pos;
    cfield_t bit_field;

    assign pos = addr_pos(bit_addr);

    always_comb begin
        bit_field      = tgt_field;
        bit_field[pos] = reduce_bit(src_field, keep, flip);
    end

    always_comb begin
        wr = '0;
        if (valid) begin
            wr.en = 1'b1;
            if (op == OP_FIELD_MAP) begin
                wr.idx  = dst_idx;
                wr.data = mask_map(src_field, dst_field, keep, flip, merge);
            end else begin
                wr.idx  = addr_field(bit_addr);
                wr.data = bit_field;
            end
        end
    end

endmodule

// File: rtl/cfmm_unit.sv
module cfmm_unit
    import cfmm_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    input  logic                req_op,
    input  logic [CF_IDX_W-1:0] src_idx,
    input  logic [CF_IDX_W-1:0] dst_idx,
    input  logic                merge_en,
    input  logic [CF_W-1:0]     keep_mask,
    input  logic [CF_W-1:0]     flip_map,
    input  logic [BADDR_W-1:0]  bit_addr,
    input  logic [CF_IDX_W-1:0] rd_idx,
    output logic [CF_W-1:0]     rd_field
);

    cfile_t fields;
    cf_wr_t wr;

    cfmm_field_file u_file (
        .clk    (clk),
        .rst    (rst),
        .wr     (wr),
        .fields (fields)
    );

    cfmm_op_unit u_op (
        .valid     (req_valid),
        .op        (cf_op_e'(req_op)),
        .dst_idx   (dst_idx),
        .src_field (fields[src_idx]),
        .dst_field (fields[dst_idx]),
        .tgt_field (fields[addr_field(bit_addr)]),
        .bit_addr  (bit_addr),
        .merge     (merge_en),
        .keep      (keep_mask),
        .flip      (flip_map),
        .wr        (wr)
    );

    assign rd_field = fields[rd_idx];

endmodule

// File: rtl/cfmm_unit_chk.sv
module cfmm_unit_chk
    import cfmm_pkg::*;
(
    input logic    clk,
    input logic    rst,
    input logic    req_valid,
    input logic    req_op,
    input cidx_t   src_idx,
    input cidx_t   dst_idx,
    input logic    merge_en,
    input cfield_t keep_mask,
    input cfield_t flip_map,
    input baddr_t  bit_addr,
    input cfile_t  fields
);

    localparam int unsigned FLAT_W = CF_COUNT * CF_W;

    logic [FLAT_W-1:0] flat;
    logic [FLAT_W-1:0] bit_hit;
    logic [FLAT_W-1:0] fld_hit;
    cidx_t   tgt;
    bsel_t   pos;
    cfield_t src_v;
    cfield_t dst_v;
    logic    exp_bit;

    assign flat    = fields;
    assign tgt     = bit_addr[CF_IDX_W-1:0];
    assign pos     = bsel_t'(CF_W-1) - bit_addr[BADDR_W-1:CF_IDX_W];
    assign src_v   = fields[src_idx];
    assign dst_v   = fields[dst_idx];
    assign exp_bit = |((src_v & keep_mask) ^ flip_map);
    assign bit_hit = FLAT_W'(1) << (int'(tgt) * CF_W + int'(pos));
    assign fld_hit = FLAT_W'({CF_W{1'b1}}) << (int'(dst_idx) * CF_W);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (flat == '0));

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> $stable(flat));

    // R2
    plain_copy_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_op && !merge_en) |=>
        (fields[$past(dst_idx)] == $past((src_v & keep_mask) ^ flip_map)));

    // R3
    merge_copy_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_op && merge_en) |=>
        (fields[$past(dst_idx)] ==
         $past(((src_v & keep_mask) | (dst_v & ~keep_mask)) ^ flip_map)));

    // R7
    copy_isolation_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_op) |=> (((flat ^ $past(flat)) & ~$past(fld_hit)) == '0));

    // R6
    bit_value_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op) |=> (fields[$past(tgt)][$past(pos)] == $past(exp_bit)));

    // R5
    bit_isolation_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op) |=> (((flat ^ $past(flat)) & ~$past(bit_hit)) == '0));

endmodule

bind cfmm_unit cfmm_unit_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_op    (req_op),
    .src_idx   (src_idx),
    .dst_idx   (dst_idx),
    .merge_en  (merge_en),
    .keep_mask (keep_mask),
    .flip_map  (flip_map),
    .bit_addr  (bit_addr),
    .fields    (fields)
);

// File: tb/cfmm_unit_bench.sv
module cfmm_unit_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0;
    logic       req_op = 1'b0;
    logic [2:0] src_idx = '0;
    logic [2:0] dst_idx = '0;
    logic       merge_en = 1'b0;
    logic [3:0] keep_mask = '0;
    logic [3:0] flip_map = '0;
    logic [4:0] bit_addr = '0;
    logic [2:0] rd_idx = '0;
    logic [3:0] rd_field;

    logic [3:0] model [8];
    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    cfmm_unit u_cfmm_unit (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_op    (req_op),
        .src_idx   (src_idx),
        .dst_idx   (dst_idx),
        .merge_en  (merge_en),
        .keep_mask (keep_mask),
        .flip_map  (flip_map),
        .bit_addr  (bit_addr),
        .rd_idx    (rd_idx),
        .rd_field  (rd_field)
    );

    task automatic check(string tag, int fld, logic [3:0] got, logic [3:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s field %0d actual %b expected %b", tag, fld, got, exp);
        end
    endtask

    task automatic check_all(string tag);
        for (int i = 0; i < 8; i++) begin
            rd_idx = 3'(i);
            #1;
            check(tag, i, rd_field, model[i]);
        end
    endtask

    // one request; the model is updated from pre-request values (R9)
    task automatic issue(bit op, int src, int dst, bit m, logic [3:0] msk,
                         logic [3:0] mp, logic [4:0] ba, string tag);
        logic [3:0] nv;
        int         fi;
        int         pos;
        @(negedge clk);
        req_valid = 1'b1;
        req_op    = op;
        src_idx   = 3'(src);
        dst_idx   = 3'(dst);
        merge_en  = m;
        keep_mask = msk;
        flip_map  = mp;
        bit_addr  = ba;
        if (op == 1'b0) begin
            fi = dst;
            nv = (model[src] & msk) | (m ? (model[dst] & ~msk) : 4'b0000);
            nv = nv ^ mp;
        end else begin
            fi  = int'(ba[2:0]);
            pos = 3 - int'(ba[4:3]);
            nv  = model[fi];
            nv[pos] = |((model[src] & msk) ^ mp);
        end
        rd_idx = 3'(fi);
        #1;
        check("R8", fi, rd_field, model[fi]);
        @(posedge clk);
        #1;
        req_valid = 1'b0;
        model[fi] = nv;
        check_all(tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        rst = 1'b0;
        for (int i = 0; i < 8; i++) model[i] = 4'b0000;
        check_all("R1");
    endtask

    initial begin
        for (int i = 0; i < 8; i++) model[i] = 4'b0000;
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        check_all("R1");

        // load each field with a distinct value through mask 0 and the map
        for (int i = 0; i < 8; i++)
            issue(1'b0, i, i, 1'b0, 4'h0, 4'(i * 3 + 5), 5'd0, "R2");

        // R2: every mask and map, no merge
        for (int k = 0; k < 256; k++)
            issue(1'b0, k % 8, (k + 3) % 8, 1'b0, 4'(k), 4'(k >> 4), 5'd0, "R2");

        // R3: every mask and map with merge
        for (int k = 0; k < 256; k++)
            issue(1'b0, (k + 5) % 8, (k + 1) % 8, 1'b1, 4'(k >> 4), 4'(k), 5'd0, "R3");

        // R4: one bit at a time, position held
        for (int b = 0; b < 4; b++) begin
            issue(1'b0, 0, 7, 1'b0, 4'hF, 4'hF, 5'd0, "R4");
            issue(1'b0, 2, 7, 1'b1, 4'(1 << b), 4'h0, 5'd0, "R4");
            issue(1'b0, 3, 7, 1'b1, 4'h0, 4'(1 << b), 5'd0, "R4");
        end

        // R9: source and destination the same
        for (int k = 0; k < 32; k++)
            issue(1'b0, k % 8, k % 8, k[0], 4'(k * 7), 4'(k * 5), 5'd0, "R9");

        // R5 R6: all bit addresses
        for (int a = 0; a < 32; a++) begin
            for (int s = 0; s < 3; s++) begin
                for (int mp = 0; mp < 16; mp++)
                    issue(1'b1, (a + mp) % 8, 0, 1'b0,
                          (s == 0) ? 4'h0 : (s == 1) ? 4'h5 : 4'hF,
                          4'(mp), 5'(a), "R5 R6");
            end
        end

        // R7: idle cycles with busy inputs
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            req_valid = 1'b0;
            req_op    = k[0];
            src_idx   = 3'($urandom);
            dst_idx   = 3'($urandom);
            merge_en  = k[1];
            keep_mask = 4'($urandom);
            flip_map  = 4'($urandom);
            bit_addr  = 5'($urandom);
            @(posedge clk);
            #1;
            check_all("R7");
        end

        // mixed random traffic
        for (int k = 0; k < 1500; k++)
            issue(1'(($urandom % 3) == 0), int'($urandom % 8), int'($urandom % 8),
                  1'($urandom), 4'($urandom), 4'($urandom), 5'($urandom),
                  "R2 R3 R6 R7");

        do_reset();

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule